// File: doc/BRIEF.md
# General-Purpose I/O Bank with Atomic Set and Clear

A bank of general-purpose pins sits behind a plain single-cycle register port. Software writes an output-data word and a per-pin direction word. It reads the pad levels back through a two-stage synchroniser. Two write-only strobe addresses change chosen output bits without a read-modify-write: one raises the selected bits and the other lowers them. Several bits can change in one access, and bits written as zero keep their value.

Each pin also has a shared-function select input. When a pin's select bit is 1, an alternate peripheral owns the pad: its output value and output enable go to the pad, and its receive line sees the pad. The GPIO view of that pin reads as zero. The GPIO registers keep their contents and stay readable and writable, so software can prepare a pin's state before handing the pad back.

The block has no state machine. It holds two storage registers, a synchroniser chain and combinational pad steering.

Top module: `gpio_setclr_bank`

## Requirements
- R1: After reset the output-data word and the direction word are zero, so `pad_oe` and `pad_out` are zero on every pin not given to the alternate function.
- R2: A write to address 0x00 loads the output-data word in the clock edge where it is sampled. A read of address 0x00 returns that word.
- R3: A write to address 0x08 loads the direction word, and a read of 0x08 returns it. A direction bit of 1 makes the pin an output (`pad_oe`=1) and 0 makes it an input, for pins not in alternate mode.
- R4: A write to address 0x10 sets to 1 every output-data bit whose write-data bit is 1 and leaves the other bits unchanged. A read of 0x10 returns zero.
- R5: A write to address 0x14 clears to 0 every output-data bit whose write-data bit is 1 and leaves the other bits unchanged. A read of 0x14 returns zero.
- R6: A read of address 0x04 returns the pad levels through a two-flip-flop synchroniser. A pad change made before clock edge k is visible after edge k+1 and not after edge k. This holds for output pins as well.
- R7: Writes to 0x04 and to any unmapped address change neither the output-data word nor the direction word. Unmapped addresses read as zero.
- R8: For a pin whose `alt_sel` bit is 1, `pad_out` follows `alt_out`, `pad_oe` follows `alt_oe`, and its bit at 0x04 reads 0. For a pin whose `alt_sel` bit is 0, `pad_out` follows the output-data bit. The registers still accept writes while the pin is in alternate mode.
- R9: `alt_in` carries the pad level for pins whose `alt_sel` bit is 1 and reads 0 for the other pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, sampled at the rising edge |
| addr | input | 8 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| pad_in | input | 32 | Pad receive levels |
| pad_out | output | 32 | Pad drive values |
| pad_oe | output | 32 | Pad output enables |
| alt_sel | input | 32 | Per-pin shared-function select |
| alt_out | input | 32 | Alternate peripheral drive values |
| alt_oe | input | 32 | Alternate peripheral output enables |
| alt_in | output | 32 | Pad levels passed to the alternate peripheral |

## Verification
The hardest case is a pin that moves between GPIO and alternate ownership while software keeps editing its registers through the set and clear addresses. Only the final register value shows up at the pad once the pin returns. The stimulus draws a fresh random `alt_sel` mask together with random set, clear, load and direction writes on every step. After each step it checks both the register readback and the steered pad outputs against a bench model. Directed steps then cover the exact latency of the synchroniser and writes aimed at the read-only and unmapped addresses.

// File: rtl/gpio_setclr_bank_pkg.sv
package gpio_setclr_bank_pkg;
    localparam int unsigned REG_ADDR_W = 8;
    localparam int unsigned SYNC_DEPTH = 2;

    typedef enum logic [REG_ADDR_W-1:0] {
        REG_DATA_OUT = 8'h00,
        REG_DATA_IN  = 8'h04,
        REG_DIR      = 8'h08,
        REG_BIT_SET  = 8'h10,
        REG_BIT_CLR  = 8'h14
    } reg_addr_e;
endpackage

// File: rtl/gpio_setclr_bank_regs.sv
module gpio_setclr_bank_regs
    import gpio_setclr_bank_pkg::*;
#(
    parameter int unsigned PINS = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [REG_ADDR_W-1:0] addr,
    input  logic [PINS-1:0]       wdata,
    input  logic [PINS-1:0]       din_view,
    output logic [PINS-1:0]       dout_q,
    output logic [PINS-1:0]       dir_q,
    output logic [PINS-1:0]       rdata
);
    logic [PINS-1:0] dout_nxt;
    logic [PINS-1:0] dir_nxt;

    always_comb begin
        dout_nxt = dout_q;
        dir_nxt  = dir_q;
        if (wr_en) begin
            case (addr)
                REG_DATA_OUT: dout_nxt = wdata;
                REG_BIT_SET:  dout_nxt = dout_q | wdata;
                REG_BIT_CLR:  dout_nxt = dout_q & ~wdata;
                REG_DIR:      dir_nxt  = wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout_q <= '0;
            dir_q  <= '0;
        end else begin
            dout_q <= dout_nxt;
            dir_q  <= dir_nxt;
        end
    end

    always_comb begin
        case (addr)
            REG_DATA_OUT: rdata = dout_q;
            REG_DATA_IN:  rdata = din_view;
            REG_DIR:      rdata = dir_q;
            default:      rdata = '0;
        endcase
    end

    // R4: ones written to the set address end up high, zeros leave bits alone
    assert_set_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == REG_BIT_SET) |=>
            ((dout_q & $past(wdata)) == $past(wdata)) &&
            ((dout_q & ~$past(wdata)) == ($past(dout_q) & ~$past(wdata))));

    // R5: ones written to the clear address end up low, zeros leave bits alone
    assert_clear_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == REG_BIT_CLR) |=>
            ((dout_q & $past(wdata)) == '0) &&
            ((dout_q & ~$past(wdata)) == ($past(dout_q) & ~$past(wdata))));

    // R3: the direction write lands in the next cycle
    assert_dir_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == REG_DIR) |=> dir_q == $past(wdata));

    // R7: a write to the input or an unmapped address disturbs no storage
    assert_no_stray_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr != REG_DATA_OUT && addr != REG_BIT_SET &&
         addr != REG_BIT_CLR && addr != REG_DIR) |=>
            $stable(dout_q) && $stable(dir_q));
endmodule

// File: rtl/gpio_setclr_bank_sync.sv
module gpio_setclr_bank_sync
    import gpio_setclr_bank_pkg::*;
#(
    parameter int unsigned PINS = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] d,
    output logic [PINS-1:0] q
);
    logic [PINS-1:0] stage [SYNC_DEPTH];

    genvar s;
    generate
        for (s = 0; s < SYNC_DEPTH; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage[s] <= '0;
                else if (s == 0) stage[s] <= d;
                else stage[s] <= stage[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q = stage[SYNC_DEPTH-1];

    logic [1:0] warm;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) warm <= '0;
        else if (warm != 2'd2) warm <= warm + 2'd1;
    end

    // R6: synchronised value equals the pad two edges earlier
    assert_sync_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd2) |-> q == $past(d, 2));
endmodule

// File: rtl/gpio_setclr_bank_padmux.sv
module gpio_setclr_bank_padmux #(
    parameter int unsigned PINS = 32
) (
    input  logic [PINS-1:0] sel,
    input  logic [PINS-1:0] gpio_out,
    input  logic [PINS-1:0] gpio_oe,
    input  logic [PINS-1:0] alt_out,
    input  logic [PINS-1:0] alt_oe,
    input  logic [PINS-1:0] pad_in,
    input  logic [PINS-1:0] sync_in,
    output logic [PINS-1:0] pad_out,
    output logic [PINS-1:0] pad_oe,
    output logic [PINS-1:0] alt_in,
    output logic [PINS-1:0] gpio_in
);
    genvar p;
    generate
        for (p = 0; p < PINS; p++) begin : g_pin
            assign pad_out[p] = sel[p] ? alt_out[p] : gpio_out[p];
            assign pad_oe[p]  = sel[p] ? alt_oe[p]  : gpio_oe[p];
            assign alt_in[p]  = sel[p] & pad_in[p];
            assign gpio_in[p] = ~sel[p] & sync_in[p];
        end
    endgenerate
endmodule

// File: rtl/gpio_setclr_bank.sv
module gpio_setclr_bank
    import gpio_setclr_bank_pkg::*;
#(
    parameter int unsigned PINS = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [REG_ADDR_W-1:0] addr,
    input  logic [PINS-1:0]       wdata,
    output logic [PINS-1:0]       rdata,
    input  logic [PINS-1:0]       pad_in,
    output logic [PINS-1:0]       pad_out,
    output logic [PINS-1:0]       pad_oe,
    input  logic [PINS-1:0]       alt_sel,
    input  logic [PINS-1:0]       alt_out,
    input  logic [PINS-1:0]       alt_oe,
    output logic [PINS-1:0]       alt_in
);
    logic [PINS-1:0] dout_q, dir_q, sync_q, din_view;

    gpio_setclr_bank_regs #(.PINS(PINS)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .din_view(din_view), .dout_q(dout_q), .dir_q(dir_q), .rdata(rdata)
    );

    gpio_setclr_bank_sync #(.PINS(PINS)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pad_in), .q(sync_q)
    );

    gpio_setclr_bank_padmux #(.PINS(PINS)) u_mux (
        .sel(alt_sel), .gpio_out(dout_q), .gpio_oe(dir_q),
        .alt_out(alt_out), .alt_oe(alt_oe), .pad_in(pad_in), .sync_in(sync_q),
        .pad_out(pad_out), .pad_oe(pad_oe), .alt_in(alt_in), .gpio_in(din_view)
    );
endmodule

// File: tb/gpio_setclr_bank_bench.sv
module gpio_setclr_bank_bench;
    localparam int CLK_PERIOD = 10;
    localparam int PINS = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wr_en = 1'b0;
    logic [7:0]      addr = '0;
    logic [PINS-1:0] wdata = '0;
    logic [PINS-1:0] rdata;
    logic [PINS-1:0] pad_in = '0;
    logic [PINS-1:0] pad_out, pad_oe, alt_in;
    logic [PINS-1:0] alt_sel = '0, alt_out = '0, alt_oe = '0;

    int checks = 0;
    int errors = 0;
    logic [PINS-1:0] m_dout = '0, m_dir = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_setclr_bank u_gpio_setclr_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .alt_sel(alt_sel), .alt_out(alt_out), .alt_oe(alt_oe), .alt_in(alt_in)
    );

    function automatic logic [PINS-1:0] steer(input logic [PINS-1:0] sel,
        input logic [PINS-1:0] a, input logic [PINS-1:0] g);
        return (sel & a) | (~sel & g);
    endfunction

    task automatic check(input string req, input logic [PINS-1:0] act,
                         input logic [PINS-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [PINS-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        case (a)
            8'h00: m_dout = d;
            8'h10: m_dout = m_dout | d;
            8'h14: m_dout = m_dout & ~d;
            8'h08: m_dir = d;
            default: ;
        endcase
    endtask

    task automatic rd(input logic [7:0] a, output logic [PINS-1:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic check_all(input string tag);
        logic [PINS-1:0] v;
        rd(8'h00, v); check({tag, " R2 dout"}, v, m_dout);
        rd(8'h08, v); check({tag, " R3 dir"}, v, m_dir);
        check({tag, " R8 pad_out"}, pad_out, steer(alt_sel, alt_out, m_dout));
        check({tag, " R3 pad_oe"}, pad_oe, steer(alt_sel, alt_oe, m_dir));
        check({tag, " R9 alt_in"}, alt_in, alt_sel & pad_in);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        logic [PINS-1:0] v;
        logic [PINS-1:0] prev_pad;
        void'($urandom(32'h5eed_0042));
        repeat (3) @(negedge clk);
        // R1: reset values
        rd(8'h00, v); check("R1 dout reset", v, '0);
        check("R1 pad_oe reset", pad_oe, '0);
        check("R1 pad_out reset", pad_out, '0);
        rst_n = 1'b1;
        @(negedge clk);
        rd(8'h08, v); check("R1 dir reset", v, '0);

        // R2/R4/R5 directed
        wr(8'h00, 32'hA5A5_0F0F); check_all("directed load");
        wr(8'h10, 32'h0000_F000); check_all("directed set R4");
        wr(8'h10, 32'h0);         check_all("set zero R4");
        rd(8'h10, v); check("R4 set reads zero", v, '0);
        wr(8'h14, 32'hFFFF_0000); check_all("directed clear R5");
        wr(8'h14, 32'h0);         check_all("clear zero R5");
        rd(8'h14, v); check("R5 clear reads zero", v, '0);
        wr(8'h08, 32'hFFFF_FFFF); check_all("all outputs R3");

        // R7: read-only and unmapped writes ignored
        wr(8'h04, 32'h1234_5678); check_all("R7 din write");
        wr(8'h20, 32'hDEAD_BEEF); check_all("R7 unmapped write");
        rd(8'h20, v); check("R7 unmapped reads zero", v, '0);
        rd(8'h0C, v); check("R7 gap reads zero", v, '0);

        // R6: two-edge latency, outputs included (all pins are outputs now)
        @(negedge clk);
        prev_pad = pad_in;
        pad_in = 32'hC3C3_3C3C;
        @(negedge clk);
        rd(8'h04, v); check("R6 not after one edge", v, prev_pad);
        @(negedge clk);
        rd(8'h04, v); check("R6 after two edges", v, 32'hC3C3_3C3C);

        // R8: alternate mode masks din, steers pads, registers stay writable
        alt_sel = 32'h0000_FFFF; alt_out = 32'h1234_5678; alt_oe = 32'h0F0F_0F0F;
        #1;
        rd(8'h04, v); check("R8 din masked", v, 32'hC3C3_0000);
        wr(8'h14, 32'hFFFF_FFFF); check_all("R8 clear while alt");
        wr(8'h10, 32'h0000_00FF); check_all("R8 set while alt");
        alt_sel = '0; #1;
        check("R8 returned pad_out", pad_out, 32'h0000_00FF);

        // random mix
        for (int i = 0; i < 300; i++) begin
            logic [2:0] op;
            logic [7:0] a;
            op = 3'($urandom_range(0, 5));
            case (op)
                3'd0: a = 8'h00;
                3'd1: a = 8'h10;
                3'd2: a = 8'h14;
                3'd3: a = 8'h08;
                3'd4: a = 8'h04;
                default: a = 8'h18;
            endcase
            alt_sel = $urandom; alt_out = $urandom; alt_oe = $urandom;
            pad_in = $urandom;
            wr(a, $urandom);
            check_all("random");
            @(negedge clk);
            rd(8'h04, v); check("R6 random din", v, pad_in & ~alt_sel);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule